// File: doc/BRIEF.md
# Ordered Transaction Commit Arbiter

This block decides which processor node in a small transactional multiprocessor may broadcast its buffered writes. Every node runs one transaction at a time. The transaction is tagged with a sequence number and a phase number, and the arbiter keeps its own record of each node's tag. A node asks for commit permission by raising a request together with an operation code. The arbiter grants permission to one node only, and only when the ordering rules allow it. The grant stays in force until the holder pulses `done`. On that pulse the arbiter updates the holder's record according to the latched operation: the node goes idle, moves on to a later phase, or waits for another sequence to empty.

Ordering applies inside each sequence only. A request can win only when its phase equals the smallest phase among the live transactions of its own sequence. Sequences never hold each other back. When several requests are eligible, a rotating pointer picks the winner. A node that overflows its write buffer takes the grant early with a spill operation. It keeps the grant for as long as its write-through lasts, and a status output stays high during that time.

Top module: `ordered_commit_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle.
- R2: A request's eligibility depends only on the phases of live transactions in its own sequence. Live transactions in other sequences, whatever their phases, never block it.
- R3: A request is eligible only when the node is running and its phase equals the minimum phase over the live (running or waiting) nodes of its sequence. Idle nodes take no part in the minimum. When the arbiter is free, it samples eligibility at a clock edge, and `gnt` rises right after that edge.
- R4: The grant stays on one node until a `done` pulse arrives from that node. `done` from any other node is ignored. After the releasing edge, `gnt` is zero for one cycle before the next grant.
- R5: Among eligible requests, the winner is the first one found after the last granted index, scanning upward with wrap-around. After reset the scan begins at node 0.
- R6: Operation codes: 0 retire, 1 advance, 2 join, 3 spill. On release, retire and spill make the node idle. Advance keeps the sequence and adds `req_inc`, latched at grant, to the phase modulo 2^16. An increment of 0 leaves the phase unchanged.
- R7: On release of a join (code 2), the phase advances as in R6. The node then reports not ready until no other node is live in the sequence `req_wseq` latched at grant. It becomes ready the cycle after that sequence drains.
- R8: `wt_hold` is high exactly while the grant is held under a spill operation.
- R9: `start_vld` is ignored for a node that is not idle. `req` is ignored for a node that is not running. A running node's record is set only by a start while it was idle.
- R10: Reset is synchronous and active high. It leaves every node idle and drives `gnt`, `node_ready`, `seq_live` and `wt_hold` to zero.
- R11: `seq_live[s]` is high when at least one node with sequence `s` is running or waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | NODES | Begin a transaction on an idle node |
| start_seq | input | NODES x SEQ_W | Sequence of the starting transaction |
| start_phase | input | NODES x PHASE_W | Phase of the starting transaction |
| req | input | NODES | Commit request, level |
| req_op | input | NODES x 2 | Operation code applied on release |
| req_inc | input | NODES x PHASE_W | Phase increment for advance and join |
| req_wseq | input | NODES x SEQ_W | Sequence a join waits on |
| done | input | NODES | Release pulse from the grant holder |
| gnt | output | NODES | One-hot commit permission |
| wt_hold | output | 1 | Grant held for a buffer-overflow write-through |
| node_ready | output | NODES | Node is running and may execute |
| seq_live | output | 2^SEQ_W | Sequence has at least one live transaction |

## Verification
Some properties are checked on every cycle by the assertions. These are: the grant is one-hot, each new grant goes to a node that was eligible one cycle earlier, the grant and its holder stay fixed until the holder's pulse, the release is followed by a gap cycle, the picked index is eligible, and a joining node stays blocked while its target sequence has other members. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model. This covers the rotating winner order across unordered phases, phase wrap at 16 bits, independence between sequences, starts and requests that are correctly ignored, and the order in which joins are released.

// File: rtl/commit_arb_pkg.sv
package commit_arb_pkg;

    typedef enum logic [1:0] {
        OP_RETIRE  = 2'd0,
        OP_ADVANCE = 2'd1,
        OP_JOIN    = 2'd2,
        OP_SPILL   = 2'd3
    } commit_op_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_RUN   = 2'd1,
        SLOT_BLOCK = 2'd2
    } slot_state_e;

    // Operations whose release ends the node's transaction entirely.
    function automatic logic op_ends_txn(commit_op_e op);
        return (op == OP_RETIRE) || (op == OP_SPILL);
    endfunction

endpackage

// File: rtl/commit_node_slot.sv
module commit_node_slot
    import commit_arb_pkg::*;
#(
    parameter int SEQ_W   = 2,
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_vld,
    input  logic [SEQ_W-1:0]   start_seq,
    input  logic [PHASE_W-1:0] start_phase,
    input  logic               commit_fire,
    input  commit_op_e         commit_op,
    input  logic [PHASE_W-1:0] commit_inc,
    input  logic [SEQ_W-1:0]   commit_wseq,
    input  logic               drained,
    output slot_state_e        state_o,
    output logic [SEQ_W-1:0]   seq_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic [SEQ_W-1:0]   wait_seq_o
);

    slot_state_e        state_q;
    logic [SEQ_W-1:0]   seq_q;
    logic [PHASE_W-1:0] phase_q;
    logic [SEQ_W-1:0]   wseq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_IDLE;
            seq_q   <= '0;
            phase_q <= '0;
            wseq_q  <= '0;
        end else begin
            unique case (state_q)
                SLOT_IDLE: begin
                    if (start_vld) begin
                        state_q <= SLOT_RUN;
                        seq_q   <= start_seq;
                        phase_q <= start_phase;
                    end
                end
                SLOT_RUN: begin
                    if (commit_fire) begin
                        if (op_ends_txn(commit_op)) begin
                            state_q <= SLOT_IDLE;
                        end else begin
                            phase_q <= phase_q + commit_inc;
                            if (commit_op == OP_JOIN) begin
                                wseq_q  <= commit_wseq;
                                state_q <= SLOT_BLOCK;
                            end
                        end
                    end
                end
                SLOT_BLOCK: begin
                    if (drained) state_q <= SLOT_RUN;
                end
                default: state_q <= SLOT_IDLE;
            endcase
        end
    end

    assign state_o    = state_q;
    assign seq_o      = seq_q;
    assign phase_o    = phase_q;
    assign wait_seq_o = wseq_q;

    // R7: a joining node stays blocked while its target sequence has other members
    assert_join_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_BLOCK && !drained) |=> (state_q == SLOT_BLOCK));

endmodule

// File: rtl/seq_order_scan.sv
module seq_order_scan #(
    parameter int NODES   = 4,
    parameter int SEQ_W   = 2,
    parameter int PHASE_W = 16,
    localparam int SEQS   = 1 << SEQ_W
) (
    input  logic [NODES-1:0]              live,
    input  logic [NODES-1:0]              runnable,
    input  logic [NODES-1:0][SEQ_W-1:0]   seq,
    input  logic [NODES-1:0][PHASE_W-1:0] phase,
    input  logic [NODES-1:0]              req,
    output logic [SEQS-1:0][NODES-1:0]    members,
    output logic [NODES-1:0]              elig
);

    logic [SEQS-1:0][PHASE_W-1:0] min_phase;

    // Per-sequence membership and lowest live phase; idle nodes are excluded.
    always_comb begin
        for (int s = 0; s < SEQS; s++) begin
            members[s]   = '0;
            min_phase[s] = '1;
            for (int n = 0; n < NODES; n++) begin
                if (live[n] && (seq[n] == SEQ_W'(s))) begin
                    members[s][n] = 1'b1;
                    if (phase[n] < min_phase[s]) min_phase[s] = phase[n];
                end
            end
        end
    end

    // A request competes only against its own sequence's oldest phase.
    always_comb begin
        for (int n = 0; n < NODES; n++) begin
            elig[n] = req[n] && runnable[n] && (phase[n] == min_phase[seq[n]]);
        end
    end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int NODES = 4,
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic [NODES-1:0] elig,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] pick
);

    always_comb begin
        any  = 1'b0;
        pick = last;
        for (int k = 1; k <= NODES; k++) begin
            int c;
            c = (int'(last) + k) % NODES;
            if (!any && elig[c]) begin
                any  = 1'b1;
                pick = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/ordered_commit_arbiter.sv
module ordered_commit_arbiter
    import commit_arb_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int SEQ_W   = 2,
    parameter int PHASE_W = 16,
    localparam int SEQS   = 1 << SEQ_W,
    localparam int IDX_W  = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NODES-1:0]              start_vld,
    input  logic [NODES-1:0][SEQ_W-1:0]   start_seq,
    input  logic [NODES-1:0][PHASE_W-1:0] start_phase,
    input  logic [NODES-1:0]              req,
    input  logic [NODES-1:0][1:0]         req_op,
    input  logic [NODES-1:0][PHASE_W-1:0] req_inc,
    input  logic [NODES-1:0][SEQ_W-1:0]   req_wseq,
    input  logic [NODES-1:0]              done,
    output logic [NODES-1:0]              gnt,
    output logic                          wt_hold,
    output logic [NODES-1:0]              node_ready,
    output logic [SEQS-1:0]               seq_live
);

    // Grant register and the operation latched with it
    logic               busy_q;
    logic [IDX_W-1:0]   hold_q;
    logic [IDX_W-1:0]   last_q;
    commit_op_e         hold_op_q;
    logic [PHASE_W-1:0] hold_inc_q;
    logic [SEQ_W-1:0]   hold_wseq_q;

    logic [NODES-1:0]              live_w;
    logic [NODES-1:0]              run_w;
    logic [NODES-1:0][SEQ_W-1:0]   seq_w;
    logic [NODES-1:0][PHASE_W-1:0] phase_w;
    logic [NODES-1:0][SEQ_W-1:0]   wseq_w;
    logic [NODES-1:0]              drained_w;
    logic [NODES-1:0]              fire_w;
    logic [SEQS-1:0][NODES-1:0]    members_w;
    logic [NODES-1:0]              elig_w;
    logic                          any_w;
    logic [IDX_W-1:0]              pick_w;
    logic                          release_w;

    assign release_w = busy_q && done[hold_q];

    generate
        for (genvar i = 0; i < NODES; i++) begin : g_slot
            slot_state_e st;

            assign fire_w[i]    = release_w && (hold_q == IDX_W'(i));
            assign drained_w[i] = (members_w[wseq_w[i]] & ~(NODES'(1) << i)) == '0;

            commit_node_slot #(
                .SEQ_W   (SEQ_W),
                .PHASE_W (PHASE_W)
            ) slot_i (
                .clk         (clk),
                .rst         (rst),
                .start_vld   (start_vld[i]),
                .start_seq   (start_seq[i]),
                .start_phase (start_phase[i]),
                .commit_fire (fire_w[i]),
                .commit_op   (hold_op_q),
                .commit_inc  (hold_inc_q),
                .commit_wseq (hold_wseq_q),
                .drained     (drained_w[i]),
                .state_o     (st),
                .seq_o       (seq_w[i]),
                .phase_o     (phase_w[i]),
                .wait_seq_o  (wseq_w[i])
            );

            assign live_w[i]     = (st != SLOT_IDLE);
            assign run_w[i]      = (st == SLOT_RUN);
            assign node_ready[i] = run_w[i];
            assign gnt[i]        = busy_q && (hold_q == IDX_W'(i));
        end

        for (genvar s = 0; s < SEQS; s++) begin : g_live
            assign seq_live[s] = |members_w[s];
        end
    endgenerate

    seq_order_scan #(
        .NODES   (NODES),
        .SEQ_W   (SEQ_W),
        .PHASE_W (PHASE_W)
    ) scan_i (
        .live     (live_w),
        .runnable (run_w),
        .seq      (seq_w),
        .phase    (phase_w),
        .req      (req),
        .members  (members_w),
        .elig     (elig_w)
    );

    rr_pick #(
        .NODES (NODES)
    ) pick_i (
        .elig (elig_w),
        .last (last_q),
        .any  (any_w),
        .pick (pick_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            hold_q      <= '0;
            last_q      <= IDX_W'(NODES - 1);
            hold_op_q   <= OP_RETIRE;
            hold_inc_q  <= '0;
            hold_wseq_q <= '0;
        end else if (busy_q) begin
            if (release_w) busy_q <= 1'b0;
        end else if (any_w) begin
            busy_q      <= 1'b1;
            hold_q      <= pick_w;
            last_q      <= pick_w;
            hold_op_q   <= commit_op_e'(req_op[pick_w]);
            hold_inc_q  <= req_inc[pick_w];
            hold_wseq_q <= req_wseq[pick_w];
        end
    end

    assign wt_hold = busy_q && (hold_op_q == OP_SPILL);

    // R1: a single holder system-wide
    assert_single_holder_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R3: a fresh grant lands on a node that was eligible at the deciding edge
    assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !$past(busy_q)) |-> |($past(elig_w) & gnt));

    // R4: holder and grant persist until the holder's own pulse
    assert_hold_until_done_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done[hold_q]) |=> (busy_q && $stable(hold_q)));

    // R4: one free cycle follows every release
    assert_gap_after_release_R4: assert property (@(posedge clk) disable iff (rst)
        release_w |=> !busy_q);

    // R5: the rotating picker only returns an eligible index
    assert_pick_valid_R5: assert property (@(posedge clk) disable iff (rst)
        any_w |-> elig_w[pick_w]);

endmodule

// File: tb/ordered_commit_arbiter_tb_top.sv
`timescale 1ns/1ps
module ordered_commit_arbiter_tb_top;

    localparam int N  = 4;
    localparam int SW = 2;
    localparam int PW = 16;
    localparam int NS = 1 << SW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0]         start_vld;
    logic [N-1:0][SW-1:0] start_seq;
    logic [N-1:0][PW-1:0] start_phase;
    logic [N-1:0]         req;
    logic [N-1:0][1:0]    req_op;
    logic [N-1:0][PW-1:0] req_inc;
    logic [N-1:0][SW-1:0] req_wseq;
    logic [N-1:0]         done;
    logic [N-1:0]         gnt;
    logic                 wt_hold;
    logic [N-1:0]         node_ready;
    logic [NS-1:0]        seq_live;

    ordered_commit_arbiter #(.NODES(N), .SEQ_W(SW), .PHASE_W(PW)) dut_i (
        .clk(clk), .rst(rst), .start_vld(start_vld), .start_seq(start_seq),
        .start_phase(start_phase), .req(req), .req_op(req_op), .req_inc(req_inc),
        .req_wseq(req_wseq), .done(done), .gnt(gnt), .wt_hold(wt_hold),
        .node_ready(node_ready), .seq_live(seq_live)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string cur_tag = "R10";

    // Reference model state (from the requirements)
    int          m_st [N];   // 0 idle, 1 running, 2 waiting
    logic [SW-1:0] m_sq [N];
    logic [SW-1:0] m_tg [N];
    logic [PW-1:0] m_ph [N];
    logic        m_busy;
    int          m_hold;
    int          m_last;
    logic [1:0]  m_op;
    logic [PW-1:0] m_inc;
    logic [SW-1:0] m_wseq;

    task automatic model_step();
        logic [N-1:0]  mem [NS];
        logic [PW-1:0] mn  [NS];
        logic [N-1:0]  el;
        int  pk;
        bit  any;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_sq[i] = '0; m_tg[i] = '0; m_ph[i] = '0;
            end
            m_busy = 1'b0; m_hold = 0; m_last = N - 1;
            m_op = 2'd0; m_inc = '0; m_wseq = '0;
            return;
        end
        for (int s = 0; s < NS; s++) begin mem[s] = '0; mn[s] = '1; end
        for (int i = 0; i < N; i++) begin
            if (m_st[i] != 0) begin
                mem[m_sq[i]][i] = 1'b1;
                if (m_ph[i] < mn[m_sq[i]]) mn[m_sq[i]] = m_ph[i];
            end
        end
        for (int i = 0; i < N; i++)
            el[i] = req[i] && (m_st[i] == 1) && (m_ph[i] == mn[m_sq[i]]);
        any = 0; pk = 0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (m_last + k) % N;
            if (!any && el[c]) begin any = 1; pk = c; end
        end
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 0 && start_vld[i]) begin
                m_st[i] = 1; m_sq[i] = start_seq[i]; m_ph[i] = start_phase[i];
            end else if (m_st[i] == 2 && ((mem[m_tg[i]] & ~(N'(1) << i)) == '0)) begin
                m_st[i] = 1;
            end
        end
        if (m_busy) begin
            if (done[m_hold]) begin
                case (m_op)
                    2'd1: m_ph[m_hold] = m_ph[m_hold] + m_inc;
                    2'd2: begin
                        m_ph[m_hold] = m_ph[m_hold] + m_inc;
                        m_tg[m_hold] = m_wseq;
                        m_st[m_hold] = 2;
                    end
                    default: m_st[m_hold] = 0;
                endcase
                m_busy = 1'b0;
            end
        end else if (any) begin
            m_busy = 1'b1; m_hold = pk; m_last = pk;
            m_op = req_op[pk]; m_inc = req_inc[pk]; m_wseq = req_wseq[pk];
        end
    endtask

    always @(posedge clk) model_step();

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [N-1:0]  eg;
        logic [N-1:0]  er;
        logic [NS-1:0] el;
        eg = '0; er = '0; el = '0;
        if (m_busy) eg[m_hold] = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 1) er[i] = 1'b1;
            if (m_st[i] != 0) el[m_sq[i]] = 1'b1;
        end
        chk("gnt holder R3 R5", 32'(gnt), 32'(eg));
        chk("gnt onehot0 R1", 32'($countones(gnt) <= 1), 32'd1);
        chk("node_ready R7 R9", 32'(node_ready), 32'(er));
        chk("seq_live R11", 32'(seq_live), 32'(el));
        chk("wt_hold R8", 32'(wt_hold), 32'(m_busy && m_op == 2'd3));
    endtask

    // Stimulus knobs
    int k_start, k_req, k_hold, k_incmax, k_seqspan, k_phspan;
    bit k_spur, k_reqany;
    logic [3:0]    k_opmask;
    logic [PW-1:0] k_phbase;
    int hold_left [N];
    logic [N-1:0] prev_gnt;

    task automatic clear_inputs();
        start_vld = '0; start_seq = '0; start_phase = '0; req = '0;
        req_op = '0; req_inc = '0; req_wseq = '0; done = '0;
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            if (gnt[i] && !prev_gnt[i]) hold_left[i] = $urandom_range(k_hold, 0);
            if (gnt[i]) begin
                req[i] = 1'b0;
                if (hold_left[i] == 0) done[i] = 1'b1;
                else begin hold_left[i]--; done[i] = 1'b0; end
            end else begin
                int op;
                done[i] = k_spur && ($urandom_range(7, 0) == 0);
                req[i]  = (node_ready[i] || k_reqany) && ($urandom_range(99, 0) < k_req);
                op = $urandom_range(3, 0);
                while (!k_opmask[op]) op = $urandom_range(3, 0);
                req_op[i]   = 2'(op);
                req_inc[i]  = PW'($urandom_range(k_incmax, 0));
                req_wseq[i] = SW'($urandom_range(k_seqspan, 0));
            end
            start_vld[i]   = ($urandom_range(99, 0) < k_start);
            start_seq[i]   = SW'($urandom_range(k_seqspan, 0));
            start_phase[i] = k_phbase + PW'($urandom_range(k_phspan, 0));
        end
        prev_gnt = gnt;
    endtask

    task automatic step(bit do_drive);
        @(negedge clk);
        compare();
        if (do_drive) drive();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clear_inputs();
        step(0);
        step(0);
        chk("reset gnt R10", 32'(gnt), 32'd0);
        chk("reset ready R10", 32'(node_ready), 32'd0);
        chk("reset live R10", 32'(seq_live), 32'd0);
        chk("reset wt_hold R10", 32'(wt_hold), 32'd0);
        rst = 1'b0;
        prev_gnt = '0;
        for (int i = 0; i < N; i++) hold_left[i] = 0;
    endtask

    task automatic knobs(int st, int rq, int hd, bit sp, logic [3:0] om, int im,
                         int ss, logic [PW-1:0] pb, int ps, bit ra);
        k_start = st; k_req = rq; k_hold = hd; k_spur = sp; k_opmask = om;
        k_incmax = im; k_seqspan = ss; k_phbase = pb; k_phspan = ps; k_reqany = ra;
    endtask

    task automatic seed_node(int i, int s, logic [PW-1:0] p);
        start_vld[i] = 1'b1; start_seq[i] = SW'(s); start_phase[i] = p;
    endtask

    task automatic run(int n);
        for (int t = 0; t < n; t++) step(1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL [%s] watchdog R1 actual cycles %0d expected below %0d", cur_tag, cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240917);
        clear_inputs();
        prev_gnt = '0;
        knobs(0, 0, 0, 0, 4'b0001, 0, 0, '0, 0, 0);

        cur_tag = "R10";
        do_reset();

        // R3: lower phase inside a sequence wins first
        cur_tag = "R3";
        do_reset();
        knobs(0, 100, 1, 0, 4'b0001, 0, 1, '0, 3, 0);
        seed_node(0, 0, 16'd0); seed_node(1, 0, 16'd1);
        seed_node(2, 1, 16'd5); seed_node(3, 1, 16'd7);
        step(0);
        run(30);

        // R2: every node in its own sequence, phases never compared across
        cur_tag = "R2";
        do_reset();
        knobs(0, 80, 2, 0, 4'b0010, 2, 3, '0, 3, 0);
        seed_node(0, 0, 16'd9); seed_node(1, 1, 16'd3);
        seed_node(2, 2, 16'd6); seed_node(3, 3, 16'd0);
        step(0);
        run(60);

        // R5: one unordered phase, rotation among all nodes
        cur_tag = "R5";
        do_reset();
        knobs(0, 100, 0, 0, 4'b0010, 0, 0, '0, 0, 0);
        for (int i = 0; i < N; i++) seed_node(i, 0, 16'd4);
        step(0);
        run(60);

        // R6: advance with wrap of the 16-bit phase
        cur_tag = "R6";
        do_reset();
        knobs(0, 90, 1, 0, 4'b0010, 2, 1, 16'hFFFE, 1, 0);
        seed_node(0, 0, 16'hFFFE); seed_node(1, 0, 16'hFFFF);
        seed_node(2, 1, 16'hFFFF); seed_node(3, 1, 16'hFFFF);
        step(0);
        run(60);

        // R7: joins waiting on sequences to drain
        cur_tag = "R7";
        do_reset();
        knobs(30, 70, 1, 0, 4'b0101, 1, 1, '0, 2, 0);
        run(150);

        // R8: spill holds with long write-through
        cur_tag = "R8";
        do_reset();
        knobs(30, 70, 6, 0, 4'b1001, 1, 1, '0, 2, 0);
        run(120);

        // R4: stray release pulses from non-holders
        cur_tag = "R4";
        do_reset();
        knobs(30, 70, 5, 1, 4'b1011, 1, 1, '0, 2, 0);
        run(120);

        // R9: starts on busy nodes and requests from non-running nodes
        cur_tag = "R9";
        do_reset();
        knobs(70, 60, 2, 1, 4'b0111, 1, 1, '0, 2, 1);
        run(120);

        // R11 and R1: random mix, restarted to clear joins that never release
        cur_tag = "R11";
        for (int e = 0; e < 15; e++) begin
            do_reset();
            knobs(25, 60, 3, 1, 4'b1111, 2, 3, '0, 3, e % 2);
            run(300);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule